// File: doc/BRIEF.md
# PWM Pattern Transfer and Dead-Time Trigger Control

This block decides when the output patterns held in a pair of staging registers are copied into the three-phase output shift register. It also decides when the dead-time timer is started. It takes in the carrier underflow pulse, strobes that mark writes to the staging registers and to the carrier register, a control-register write port, and the three per-phase one-shot pulse levels. It drives a one-cycle load strobe for the shift register and a one-cycle dead-time trigger. The shift register and the dead-time counters are separate blocks.

A transfer trigger comes from one of three sources: a carrier underflow, a control write that sets the software-trigger bit, or a carrier-register write while the write-trigger option is on. The block has two modulation modes. In triangular mode a staging write arms a pending flag, and only the first trigger after that write loads the shift register. In sawtooth mode every trigger loads the shift register and also starts dead time. Sawtooth mode is allowed only with phase mode 0 and with the carrier reloading on underflow. In any other configuration the block falls back to triangular mode.

Top module: `pwm_xfer_ctl`

## Requirements
- R1: After reset, `load_stb`, `dt_trig`, `xfer_pend` and `rd_ctl` are all 0, and the mode is triangular.
- R2: A transfer trigger is `carr_uf`, or `ctl_we` with `ctl_swtrig`=1, or `carr_we` with `cfg_wtrig_en`=1. A `carr_we` with `cfg_wtrig_en`=0 is not a trigger.
- R3: `rd_ctl[1]`, the software-trigger bit as read back, is always 0. `rd_ctl[0]` reads 1 when sawtooth mode is active.
- R4: In triangular mode (`rd_ctl[0]`=0), `load_stb` is 1 for one cycle, in the cycle after a trigger, only if a staging write has occurred since the last load. Later triggers produce no load until the next staging write.
- R5: In sawtooth mode, `load_stb` is 1 in the cycle after every trigger.
- R6: `dt_trig` is 1 in the cycle after any bit of `os_pulse` falls from 1 to 0. In triangular mode, triggers alone never raise `dt_trig`.
- R7: In sawtooth mode, `dt_trig` is also 1 in the cycle after every trigger.
- R8: `ctl_we` with `ctl_saw`=1 selects sawtooth mode from the next cycle, but only while `cfg_mode1`=0 and `cfg_reload_alt`=0. In any other configuration the mode is forced to triangular.
- R9: `xfer_pend` becomes 1 in the cycle after any bit of `stg_we` is 1. It becomes 0 in the cycle in which `load_stb` is 1.
- R10: A staging write and a trigger in the same cycle give a load in the next cycle, with `xfer_pend`=0. A trigger that arrives with a mode write uses the mode that was in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode1 | input | 1 | Phase mode 1 selected (blocks sawtooth) |
| cfg_reload_alt | input | 1 | Carrier reload not on underflow (blocks sawtooth) |
| cfg_wtrig_en | input | 1 | Carrier-register writes act as triggers |
| ctl_we | input | 1 | Control register write strobe |
| ctl_saw | input | 1 | Write data: 1 requests sawtooth mode |
| ctl_swtrig | input | 1 | Write data: 1 issues a software trigger |
| stg_we | input | 2 | Write strobes of the two staging registers |
| carr_we | input | 1 | Carrier register write strobe |
| carr_uf | input | 1 | Carrier underflow pulse |
| os_pulse | input | 3 | Per-phase one-shot pulse levels |
| load_stb | output | 1 | Shift register load strobe |
| dt_trig | output | 1 | Dead-time timer trigger |
| xfer_pend | output | 1 | A staging write is waiting for transfer |
| rd_ctl | output | 2 | Readback: bit 1 software trigger (always 0), bit 0 sawtooth active |

## Verification
The assertions treat every input as a plain level that is sampled on each rising edge. They place no limit on how often triggers, staging writes or one-shot edges arrive. The `$past` checks assume that the inputs are held at 0 while reset is asserted, and the bench does this. The random stimulus draws every input independently, each cycle, from a fixed seed. Trigger and staging-write rates are kept low so that triangular loads, suppressed triggers and pending flags all occur. The configuration bits change only rarely, so that long runs in sawtooth mode take place alongside the cases where sawtooth is refused.

// File: rtl/pwm_xfer_pkg.sv
package pwm_xfer_pkg;
  typedef enum logic {
    MOD_TRI = 1'b0,
    MOD_SAW = 1'b1
  } mod_e;

  function automatic logic saw_allowed(input logic mode1, input logic reload_alt);
    return !mode1 && !reload_alt;
  endfunction
endpackage

// File: rtl/pwm_trig_src.sv
module pwm_trig_src (
  input  logic ctl_we,
  input  logic ctl_swtrig,
  input  logic carr_we,
  input  logic cfg_wtrig_en,
  input  logic carr_uf,
  output logic trig
);
  logic sw_hit;
  logic wr_hit;

  always_comb begin
    sw_hit = ctl_we && ctl_swtrig;
    wr_hit = carr_we && cfg_wtrig_en;
    trig   = carr_uf || sw_hit || wr_hit;
  end
endmodule

// File: rtl/pwm_fall_det.sv
module pwm_fall_det #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] os_in,
  output logic           fall_any
);
  logic [NPH-1:0] prev_q;
  logic [NPH-1:0] prev_d;
  logic [NPH-1:0] fall;

  genvar g;
  generate
    for (g = 0; g < NPH; g++) begin : g_ph
      always_comb begin
        fall[g]   = prev_q[g] && !os_in[g];
        prev_d[g] = os_in[g];
      end
    end
  endgenerate

  always_comb fall_any = |fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/pwm_mode_reg.sv
module pwm_mode_reg
  import pwm_xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_saw,
  input  logic cfg_mode1,
  input  logic cfg_reload_alt,
  output mod_e mode
);
  mod_e mode_q;
  mod_e mode_d;
  logic mode_en;

  always_comb begin
    mode_en = 1'b0;
    mode_d  = mode_q;
    if (!saw_allowed(cfg_mode1, cfg_reload_alt)) begin
      mode_en = 1'b1;
      mode_d  = MOD_TRI;
    end else if (ctl_we) begin
      mode_en = 1'b1;
      mode_d  = ctl_saw ? MOD_SAW : MOD_TRI;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MOD_TRI;
    else if (mode_en) mode_q <= mode_d;
  end

  always_comb mode = mode_q;

  assert_saw_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_mode1 || cfg_reload_alt) |-> (mode_q == MOD_TRI));
endmodule

// File: rtl/pwm_xfer_seq.sv
module pwm_xfer_seq
  import pwm_xfer_pkg::*;
#(
  parameter int NSTG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic [NSTG-1:0] stg_we,
  input  mod_e            mode,
  output logic            load_q,
  output logic            pend_q
);
  logic stg_any;
  logic load_d;
  logic pend_d;

  always_comb begin
    stg_any = |stg_we;
    load_d  = trig && ((mode == MOD_SAW) || pend_q || stg_any);
    if (load_d) pend_d = 1'b0;
    else        pend_d = pend_q || stg_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      load_q <= load_d;
      pend_q <= pend_d;
    end
  end

  assert_tri_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && $past(mode == MOD_TRI)) |-> ($past(pend_q) || $past(|stg_we)));
  assert_saw_every_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trig && (mode == MOD_SAW)) |-> load_q);
  assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|stg_we) |-> (pend_q || load_q));
  assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> !pend_q);
endmodule

// File: rtl/pwm_xfer_ctl.sv
module pwm_xfer_ctl
  import pwm_xfer_pkg::*;
#(
  parameter int NSTG = 2,
  parameter int NPH  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_mode1,
  input  logic            cfg_reload_alt,
  input  logic            cfg_wtrig_en,
  input  logic            ctl_we,
  input  logic            ctl_saw,
  input  logic            ctl_swtrig,
  input  logic [NSTG-1:0] stg_we,
  input  logic            carr_we,
  input  logic            carr_uf,
  input  logic [NPH-1:0]  os_pulse,
  output logic            load_stb,
  output logic            dt_trig,
  output logic            xfer_pend,
  output logic [1:0]      rd_ctl
);
  logic trig;
  logic fall_any;
  mod_e mode;
  logic dt_d;
  logic dt_q;

  pwm_trig_src i_trig (
    .ctl_we       (ctl_we),
    .ctl_swtrig   (ctl_swtrig),
    .carr_we      (carr_we),
    .cfg_wtrig_en (cfg_wtrig_en),
    .carr_uf      (carr_uf),
    .trig         (trig)
  );

  pwm_fall_det #(.NPH(NPH)) i_fall (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_in    (os_pulse),
    .fall_any (fall_any)
  );

  pwm_mode_reg i_mode (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_we         (ctl_we),
    .ctl_saw        (ctl_saw),
    .cfg_mode1      (cfg_mode1),
    .cfg_reload_alt (cfg_reload_alt),
    .mode           (mode)
  );

  pwm_xfer_seq #(.NSTG(NSTG)) i_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (trig),
    .stg_we (stg_we),
    .mode   (mode),
    .load_q (load_stb),
    .pend_q (xfer_pend)
  );

  always_comb dt_d = fall_any || ((mode == MOD_SAW) && trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dt_q <= 1'b0;
    else        dt_q <= dt_d;
  end

  always_comb begin
    dt_trig = dt_q;
    rd_ctl  = {1'b0, mode == MOD_SAW};
  end

  assert_dt_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dt_trig |-> $past(fall_any || ((mode == MOD_SAW) && trig)));
  assert_saw_dt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past((mode == MOD_SAW) && trig) |-> dt_trig);
  assert_sw_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl[1] == 1'b0);
  assert_trig_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(carr_uf || (ctl_we && ctl_swtrig) || (carr_we && cfg_wtrig_en)));
endmodule

// File: tb/test_pwm_xfer_ctl.sv
module test_pwm_xfer_ctl;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_mode1, cfg_reload_alt, cfg_wtrig_en;
  logic ctl_we, ctl_saw, ctl_swtrig;
  logic [1:0] stg_we;
  logic carr_we, carr_uf;
  logic [2:0] os_pulse;
  logic load_stb, dt_trig, xfer_pend;
  logic [1:0] rd_ctl;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  logic m_saw, m_pend;
  logic [2:0] m_prev;
  logic e_load, e_dt;

  always #2 clk = ~clk;

  pwm_xfer_ctl i_pwm_xfer_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_mode1(cfg_mode1), .cfg_reload_alt(cfg_reload_alt),
    .cfg_wtrig_en(cfg_wtrig_en), .ctl_we(ctl_we), .ctl_saw(ctl_saw), .ctl_swtrig(ctl_swtrig),
    .stg_we(stg_we), .carr_we(carr_we), .carr_uf(carr_uf), .os_pulse(os_pulse),
    .load_stb(load_stb), .dt_trig(dt_trig), .xfer_pend(xfer_pend), .rd_ctl(rd_ctl)
  );

  function automatic logic f_trig(logic uf, logic we, logic sw, logic cw, logic en);
    return uf || (we && sw) || (cw && en);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    ctl_we = 0; ctl_saw = 0; ctl_swtrig = 0; stg_we = 0;
    carr_we = 0; carr_uf = 0; os_pulse = 0;
  endtask

  task automatic tick(string tag);
    logic t;
    t      = f_trig(carr_uf, ctl_we, ctl_swtrig, carr_we, cfg_wtrig_en);
    e_load = t && (m_saw || m_pend || (|stg_we));
    e_dt   = (|(m_prev & ~os_pulse)) || (m_saw && t);
    m_pend = e_load ? 1'b0 : (m_pend || (|stg_we));
    if (cfg_mode1 || cfg_reload_alt) m_saw = 1'b0;
    else if (ctl_we) m_saw = ctl_saw;
    m_prev = os_pulse;
    @(posedge clk);
    #1;
    check({tag, " load"}, load_stb, e_load);
    check({tag, " dt"}, dt_trig, e_dt);
    check({tag, " pend"}, xfer_pend, m_pend);
    check({tag, " mode"}, rd_ctl[0], m_saw);
    check("R3 swtrig readback", rd_ctl[1], 1'b0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0;
    cfg_mode1 = 0; cfg_reload_alt = 0; cfg_wtrig_en = 0;
    clear_in();
    m_saw = 0; m_pend = 0; m_prev = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset load", load_stb, 1'b0);
    check("R1 reset dt", dt_trig, 1'b0);
    check("R1 reset pend", xfer_pend, 1'b0);
    check("R1 reset rd", rd_ctl[0], 1'b0);
    rst_n = 1;
    tick("R1 idle");

    // R4: trigger without a staging write gives no load
    carr_uf = 1; tick("R4 no pending"); clear_in();
    stg_we = 2'b01; tick("R9 set"); clear_in();
    // R2: carrier write with the option off is not a trigger
    carr_we = 1; tick("R2 wtrig off"); clear_in();
    cfg_wtrig_en = 1; carr_we = 1; tick("R2 wtrig on R4"); clear_in();
    carr_uf = 1; tick("R4 second trig"); clear_in();
    ctl_we = 1; ctl_swtrig = 1; tick("R4 swtrig no pend"); clear_in();
    // R10: write and trigger in the same cycle
    stg_we = 2'b10; carr_uf = 1; tick("R10 same cycle"); clear_in();
    // R6: falling edge of a one-shot
    os_pulse = 3'b100; tick("R6 rise"); os_pulse = 0; tick("R6 fall"); clear_in();
    // R8: sawtooth refused in phase mode 1
    cfg_mode1 = 1; ctl_we = 1; ctl_saw = 1; tick("R8 refused"); clear_in();
    cfg_mode1 = 0; cfg_reload_alt = 1; ctl_we = 1; ctl_saw = 1; tick("R8 refused reload"); clear_in();
    cfg_reload_alt = 0;
    // R10: mode write and trigger together use old mode
    ctl_we = 1; ctl_saw = 1; ctl_swtrig = 1; tick("R10 old mode"); clear_in();
    carr_uf = 1; tick("R5 R7 saw trig"); clear_in();
    carr_uf = 1; tick("R5 R7 saw trig again"); clear_in();
    cfg_mode1 = 1; tick("R8 forced back"); clear_in();
    cfg_mode1 = 0;

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(63) == 0) cfg_mode1 = $urandom_range(3) == 0;
      if ($urandom_range(63) == 0) cfg_reload_alt = $urandom_range(3) == 0;
      if ($urandom_range(31) == 0) cfg_wtrig_en = $urandom_range(1) == 1;
      ctl_we     = $urandom_range(15) == 0;
      ctl_saw    = $urandom_range(2) != 0;
      ctl_swtrig = $urandom_range(2) == 0;
      stg_we     = ($urandom_range(7) == 0) ? 2'($urandom_range(3)) : 2'b00;
      carr_we    = $urandom_range(9) == 0;
      carr_uf    = $urandom_range(7) == 0;
      if ($urandom_range(3) == 0) os_pulse = 3'($urandom_range(7));
      tick("random R2 R4 R5 R6 R7 R8 R9 R10");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule